// File: doc/BRIEF.md
# Discoverable-Parameter Table Read Responder

This block serves the serial-flash parameter-discovery read (opcode 0x5A) out of a small constant table synthesized as a ROM. The command decoder in front of it passes one request per transaction. A request carries the opcode, a 24-bit start address, the number of bytes the host clocked in and the number of bytes the host wants back. The block answers with exactly that many bytes, one per clock, each marked by a valid flag. The final byte also carries a last flag.

The host may send one dummy byte too few or several too many. With one too few, the block emits a filler 0xFF first and then the table data. With extra bytes, the block moves the start forward because those bytes were already clocked out. The start position is reduced modulo the table length, which need not be a power of two. A read that runs off the end of the table returns 0xFF. The remainder is computed by a serial divider, one address bit per clock, so every response begins a fixed number of cycles after the request is accepted.

A configuration input states whether the table exists. Without it, and for any other opcode, the block still returns the requested number of bytes, all 0xFF.

Top module: `sfdp_responder`

## Requirements
- R1: After reset `rsp_valid` and `rsp_last` are 0 and `req_ready` is 1.
- R2: An accepted request (`req_valid` and `req_ready` high at a clock edge) with read count N yields exactly N consecutive bytes. The first byte is valid after the (ADDR_W+3)-th edge following the accepting edge, which is the 27th for the default 24-bit address. `rsp_last` is high only with the N-th byte. N = 0 produces no byte, and `req_ready` returns high.
- R3: If `cfg_sfdp_en` is 0, or the opcode is not 0x5A, or the written count is below 4, every response byte is 0xFF.
- R4: With a written count of exactly 4, response byte 0 is 0xFF. Response byte i ≥ 1 carries table position S + i − 1.
- R5: With a written count of exactly 5, response byte i carries table position S + i, where S = address mod TBL_LEN.
- R6: With a written count W > 5, the start is S = (address + W − 5) mod TBL_LEN.
- R7: A start address at or past TBL_LEN wraps modulo TBL_LEN, across the full 24-bit address range.
- R8: A response position at or past TBL_LEN returns 0xFF. Only the start wraps, not the running position.
- R9: Table encoding, by byte position p:
  - p 0 to 3: 0x53 0x46 0x44 0x50.
  - p 4 to 7: 0x06 0x01 0x00 0xFF.
  - p 8 to 11: 0x00 0x06 0x01 PT_DW.
  - p 12 to 14: PT_OFS as a little-endian 24-bit value.
  - p 15: 0xFF.
  - p in [PT_OFS, PT_OFS + 4·PT_DW): the low byte of 37·p + 11.
  - All other positions: 0xFF.
  - Defaults: TBL_LEN 88, PT_OFS 32, PT_DW 9.
- R10: While `req_ready` is 0, `req_valid` is ignored. The current response does not change, and no further response follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sfdp_en | input | 1 | Parameter table present |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_opcode | input | 8 | Command opcode |
| req_addr | input | ADDR_W | Start address bytes from the command |
| req_wr_count | input | 8 | Bytes written by host, including the opcode |
| req_rd_count | input | 8 | Bytes to return |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the response |

## Verification
All results are due a fixed number of edges after the accepting edge. Response byte i appears after edge ADDR_W+3+i, and `req_ready` rises together with the last byte. The bench counts edges from acceptance and samples on the falling edge that follows each counted rising edge. At every such sample it compares valid, data and last with a model built from the requirements. That comparison also shows that nothing is emitted early or late. For the ignored-request case the bench keeps sampling for a full latency beyond the end of the response, to prove that no second answer appears.

// File: rtl/sfdp_pkg.sv
package sfdp_pkg;

    localparam int unsigned CNT_W = 8;
    localparam logic [7:0] DISCOVERY_OPCODE = 8'h5A;
    localparam logic [7:0] FILL_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REDUCE,
        ST_STREAM
    } resp_state_e;

    typedef struct packed {
        logic             table_mode;  // table bytes may be returned
        logic             dummy_lead;  // host omitted the dummy byte
        logic [CNT_W-1:0] rd_total;    // bytes to return
    } req_ctx_t;

    // Content of the parameter table at position idx.
    function automatic logic [7:0] table_byte(int unsigned idx,
                                              int unsigned pt_ofs,
                                              int unsigned pt_dw);
        logic [7:0] b;
        logic [31:0] prod;
        prod = idx * 37 + 11;
        b = FILL_BYTE;
        case (idx)
            0: b = 8'h53;
            1: b = 8'h46;
            2: b = 8'h44;
            3: b = 8'h50;
            4: b = 8'h06;
            5: b = 8'h01;
            6: b = 8'h00;
            8: b = 8'h00;
            9: b = 8'h06;
            10: b = 8'h01;
            11: b = pt_dw[7:0];
            12: b = pt_ofs[7:0];
            13: b = pt_ofs[15:8];
            14: b = pt_ofs[23:16];
            default: begin
                if (idx >= pt_ofs && idx < pt_ofs + 4 * pt_dw)
                    b = prod[7:0];
            end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sfdp_rom.sv
module sfdp_rom #(
    parameter int unsigned TBL_LEN = 88,
    parameter int unsigned PT_OFS  = 32,
    parameter int unsigned PT_DW   = 9,
    parameter int unsigned IDX_W   = $clog2(TBL_LEN)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       data
);
    import sfdp_pkg::*;

    logic [7:0] cells [TBL_LEN];

    for (genvar g = 0; g < TBL_LEN; g++) begin : g_cell
        assign cells[g] = table_byte(g, PT_OFS, PT_DW);
    end

    always_comb begin
        if (int'(idx) < TBL_LEN)
            data = cells[idx];
        else
            data = FILL_BYTE;
    end
endmodule

// File: rtl/sfdp_mod_reducer.sv
module sfdp_mod_reducer #(
    parameter int unsigned DIV_W   = 25,
    parameter int unsigned MODULUS = 88,
    parameter int unsigned REM_W   = $clog2(MODULUS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] dividend,
    output logic             done,
    output logic [REM_W-1:0] remainder
);
    localparam int unsigned LEFT_W = $clog2(DIV_W + 1);

    logic [DIV_W-1:0]  shr;
    logic [LEFT_W-1:0] left;
    logic [REM_W:0]    trial;
    logic              fits;

    always_comb begin
        trial = {remainder, shr[DIV_W-1]};
        fits  = int'(trial) >= MODULUS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shr       <= '0;
            left      <= '0;
            remainder <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                shr       <= dividend;
                remainder <= '0;
                left      <= LEFT_W'(DIV_W);
            end else if (left != '0) begin
                shr  <= shr << 1;
                left <= left - 1'b1;
                done <= (left == LEFT_W'(1));
                if (fits)
                    remainder <= REM_W'(trial - (REM_W+1)'(MODULUS));
                else
                    remainder <= trial[REM_W-1:0];
            end
        end
    end
endmodule

// File: rtl/sfdp_responder.sv
module sfdp_responder #(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned TBL_LEN = 88,
    parameter int unsigned PT_OFS  = 32,
    parameter int unsigned PT_DW   = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_sfdp_en,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [7:0]                 req_opcode,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [sfdp_pkg::CNT_W-1:0] req_wr_count,
    input  logic [sfdp_pkg::CNT_W-1:0] req_rd_count,
    output logic                       rsp_valid,
    output logic [7:0]                 rsp_data,
    output logic                       rsp_last
);
    import sfdp_pkg::*;

    localparam int unsigned OFFS_W = ADDR_W + 1;
    localparam int unsigned BASE_W = $clog2(TBL_LEN);
    localparam int unsigned POS_W  = $clog2(TBL_LEN + (1 << CNT_W)) + 1;

    resp_state_e       state;
    req_ctx_t          ctx, ctx_next;
    logic              accept;
    logic [CNT_W-1:0]  surplus;
    logic [OFFS_W-1:0] raw_start;
    logic              red_done;
    logic [BASE_W-1:0] red_rem;
    logic [BASE_W-1:0] base;
    logic [CNT_W-1:0]  idx;
    logic [POS_W-1:0]  pos;
    logic [7:0]        rom_data;
    logic [7:0]        pick;
    logic              is_final;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Start offset before the modulo: surplus bytes already consumed data.
    always_comb begin
        surplus   = (req_wr_count > CNT_W'(5)) ? req_wr_count - CNT_W'(5) : '0;
        raw_start = OFFS_W'(req_addr) + OFFS_W'(surplus);
        ctx_next.table_mode = cfg_sfdp_en && (req_opcode == DISCOVERY_OPCODE)
                              && (req_wr_count >= CNT_W'(4));
        ctx_next.dummy_lead = (req_wr_count == CNT_W'(4));
        ctx_next.rd_total   = req_rd_count;
    end

    sfdp_mod_reducer #(
        .DIV_W  (OFFS_W),
        .MODULUS(TBL_LEN),
        .REM_W  (BASE_W)
    ) u_reduce (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .dividend (raw_start),
        .done     (red_done),
        .remainder(red_rem)
    );

    always_comb begin
        pos = POS_W'(base) + POS_W'(idx) - POS_W'(ctx.dummy_lead);
    end

    sfdp_rom #(
        .TBL_LEN(TBL_LEN),
        .PT_OFS (PT_OFS),
        .PT_DW  (PT_DW),
        .IDX_W  (BASE_W)
    ) u_rom (
        .idx (pos[BASE_W-1:0]),
        .data(rom_data)
    );

    always_comb begin
        pick = FILL_BYTE;
        if (ctx.table_mode && !(ctx.dummy_lead && idx == '0)
            && int'(pos) < TBL_LEN)
            pick = rom_data;
        is_final = (idx == ctx.rd_total - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctx       <= '0;
            base      <= '0;
            idx       <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_last  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        ctx   <= ctx_next;
                        state <= ST_REDUCE;
                    end
                end
                ST_REDUCE: begin
                    if (red_done) begin
                        base  <= red_rem;
                        idx   <= '0;
                        state <= (ctx.rd_total == '0) ? ST_IDLE : ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= pick;
                    rsp_last  <= is_final;
                    idx       <= idx + 1'b1;
                    if (is_final)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sfdp_responder_chk.sv
module sfdp_responder_chk #(
    parameter int unsigned ADDR_W = 24
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cfg_sfdp_en,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [7:0]                 req_opcode,
    input logic [ADDR_W-1:0]          req_addr,
    input logic [sfdp_pkg::CNT_W-1:0] req_wr_count,
    input logic [sfdp_pkg::CNT_W-1:0] req_rd_count,
    input logic                       rsp_valid,
    input logic [7:0]                 rsp_data,
    input logic                       rsp_last
);
    logic expect_fill;

    always_ff @(posedge clk) begin
        if (rst)
            expect_fill <= 1'b0;
        else if (req_valid && req_ready)
            expect_fill <= !(cfg_sfdp_en && req_opcode == 8'h5A
                             && req_wr_count >= 8'd4);
    end

    a_r1_busy_while_stream: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_last |-> !req_ready);

    a_r2_last_with_valid: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);

    a_r2_no_gap: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_last |=> rsp_valid);

    a_r2_end_after_last: assert property (@(posedge clk) disable iff (rst)
        rsp_last |=> !rsp_valid);

    a_r3_fill_when_off: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && expect_fill |-> rsp_data == 8'hFF);

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);
endmodule

bind sfdp_responder sfdp_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_sfdp_en (cfg_sfdp_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_opcode  (req_opcode),
    .req_addr    (req_addr),
    .req_wr_count(req_wr_count),
    .req_rd_count(req_rd_count),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_last    (rsp_last)
);

// File: tb/sfdp_responder_test.sv
`timescale 1ns/1ps
module sfdp_responder_test;
    localparam int ADDR_W = 24;
    localparam int TLEN   = 88;
    localparam int PTO    = 32;
    localparam int PTD    = 9;
    localparam int LAT    = ADDR_W + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_sfdp_en = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [7:0] req_opcode = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0] req_wr_count = '0;
    logic [7:0] req_rd_count = '0;
    logic rsp_valid;
    logic [7:0] rsp_data;
    logic rsp_last;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sfdp_responder uut (
        .clk(clk), .rst(rst), .cfg_sfdp_en(cfg_sfdp_en),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_addr(req_addr),
        .req_wr_count(req_wr_count), .req_rd_count(req_rd_count),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
    );

    // R9 encoding
    function automatic int tbl(int p);
        case (p)
            0: return 8'h53;
            1: return 8'h46;
            2: return 8'h44;
            3: return 8'h50;
            4: return 8'h06;
            5: return 8'h01;
            6: return 8'h00;
            8: return 8'h00;
            9: return 8'h06;
            10: return 8'h01;
            11: return PTD;
            12: return PTO & 255;
            13: return (PTO >> 8) & 255;
            14: return (PTO >> 16) & 255;
            default: begin
                if (p >= PTO && p < PTO + 4 * PTD) return (37 * p + 11) & 255;
                return 8'hFF;
            end
        endcase
    endfunction

    function automatic int exp_byte(bit en, int op, int addr, int wr, int i);
        int s;
        int k;
        if (!en || op != 8'h5A || wr < 4) return 8'hFF;          // R3
        s = (addr + ((wr > 5) ? wr - 5 : 0)) % TLEN;             // R5 R6 R7
        k = i;
        if (wr == 4) begin                                       // R4
            if (i == 0) return 8'hFF;
            k = i - 1;
        end
        if (s + k >= TLEN) return 8'hFF;                         // R8
        return tbl(s + k);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic run_req(bit en, int op, int addr, int wr, int rd,
                           string req, bit poke);
        int span;
        bit ev;
        int ed;
        @(negedge clk);
        cfg_sfdp_en  = en;
        req_opcode   = op[7:0];
        req_addr     = addr[ADDR_W-1:0];
        req_wr_count = wr[7:0];
        req_rd_count = rd[7:0];
        req_valid    = 1'b1;
        chk(req_ready === 1'b1, "R2", "ready before request", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        span = poke ? LAT + rd + LAT + 2 : LAT + rd;
        for (int k = 1; k <= span; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke && k == 5) begin
                req_valid    = 1'b1;                 // R10 poke while busy
                req_opcode   = 8'h5A;
                req_addr     = 24'h000003;
                req_wr_count = 8'd5;
                req_rd_count = 8'd3;
                cfg_sfdp_en  = 1'b1;
            end
            if (poke && k == 6) req_valid = 1'b0;
            ev = (k >= LAT) && (k < LAT + rd);
            chk(rsp_valid === ev, poke ? "R10" : "R2", "rsp_valid",
                int'(rsp_valid), int'(ev));
            if (ev) begin
                ed = exp_byte(en, op, addr, wr, k - LAT);
                chk(int'(rsp_data) == ed, req, "rsp_data", int'(rsp_data), ed);
                chk(rsp_last === (k == LAT + rd - 1), "R2", "rsp_last",
                    int'(rsp_last), int'(k == LAT + rd - 1));
            end
        end
        chk(req_ready === 1'b1, "R2", "ready after response", int'(req_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(rsp_valid === 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
        chk(rsp_last === 1'b0, "R1", "rsp_last", int'(rsp_last), 0);
        chk(req_ready === 1'b1, "R1", "req_ready", int'(req_ready), 1);

        run_req(1, 8'h5A, 0, 5, 16, "R9", 0);          // signature and header
        run_req(1, 8'h5A, PTO, 5, 20, "R9", 0);        // parameter region
        run_req(1, 8'h5A, 8, 5, 6, "R5", 0);
        run_req(1, 8'h5A, 0, 4, 6, "R4", 0);
        run_req(1, 8'h5A, 3, 8, 6, "R6", 0);
        run_req(1, 8'h5A, 85, 9, 5, "R6", 0);          // surplus pushes past end, wraps
        run_req(1, 8'h5A, TLEN, 5, 4, "R7", 0);
        run_req(1, 8'h5A, 24'hFFFFFF, 5, 4, "R7", 0);
        run_req(1, 8'h5A, 24'h800000 + 1, 4, 4, "R7", 0);
        run_req(1, 8'h5A, 80, 5, 14, "R8", 0);
        run_req(1, 8'h5A, 87, 4, 3, "R8", 0);
        run_req(0, 8'h5A, 0, 5, 6, "R3", 0);
        run_req(1, 8'h03, 0, 5, 6, "R3", 0);
        run_req(1, 8'h5A, 0, 3, 6, "R3", 0);
        run_req(1, 8'h5A, 0, 5, 0, "R2", 0);
        run_req(1, 8'h5A, 0, 5, 1, "R2", 0);
        run_req(1, 8'h5A, 10, 5, 6, "R10", 1);

        for (int n = 0; n < 50; n++) begin
            bit en;
            int op, addr, wr, rd;
            en   = ($urandom % 10) != 0;
            op   = (($urandom % 8) != 0) ? 8'h5A : int'($urandom % 256);
            addr = (($urandom % 2) != 0) ? int'($urandom % 120)
                                         : int'($urandom % (1 << ADDR_W));
            wr   = int'($urandom % 11);
            rd   = int'($urandom % 15);
            run_req(en, op, addr, wr, rd, "R6", 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule